// File: doc/BRIEF.md
# Transmit Packet Buffer with Request-Driven Read Port

This block sits between a frame producer in the fabric and an Ethernet MAC transmitter. The producer pushes frames one word at a time through a write port. Each word carries a start marker, an end marker and an error marker. The words sit in a circular store until the MAC pulls them out. All logic runs in one transmit clock domain.

The MAC side is request-driven. The block raises `frame_ready` once a whole frame is buffered. The MAC then issues single-cycle read pulses. Every pulse is answered, one cycle later, by exactly one response: a valid word or an underflow. The MAC reports outcomes on a status bus. Any nonzero status is acknowledged by inverting `status_tog`, and it starts a flush handshake on `flushed`: the line goes high for a fixed number of cycles, and its falling edge marks the end of the flush.

Status bit 0 means a collision. On a collision the read position returns to the start of the frame in progress, so the frame is sent again. Any other nonzero status empties the whole buffer. An error marked on a word without any status from the MAC changes nothing, and the next frame flows as usual.

Top module: `tx_pkt_fifo_resp`

## Requirements
- R1: While reset is asserted, `frame_ready`, `rsp_valid`, `rsp_underflow`, `flushed`, `status_tog` and `wr_full` are all 0.
- R2: `frame_ready` is 1 exactly when at least one written end-of-frame word has not yet been read out and no flush handshake is running. It rises in the cycle after the end-of-frame word is written.
- R3: A read request in cycle N produces exactly one of `rsp_valid` or `rsp_underflow` in cycle N+1, each for one cycle. Neither output is asserted without a preceding request.
- R4: Valid responses return the stored words in write order. `rsp_data`, `rsp_sop` and `rsp_eop` are as written, and a one-word frame carries both `rsp_sop` and `rsp_eop` on the same response.
- R5: `rsp_err` accompanies a valid response on exactly the word written with `wr_err`. Without MAC status, an error-marked frame has no further effect and the next frame is delivered intact.
- R6: A read request that finds no unread word is answered with `rsp_underflow`.
- R7: When `mac_status` turns nonzero after having been zero, and no flush is running, `status_tog` inverts in the next cycle. It inverts once per event. Status must return to zero before it can be taken again.
- R8: In the cycle after status is taken, `flushed` rises. It stays high for FLUSH_CYCLES cycles and then falls. `frame_ready` is 0 while `flushed` is high.
- R9: A status with bit 0 clear empties the buffer. Writes in the capture cycle and during the handshake are ignored, so a read afterwards underflows.
- R10: A status with bit 0 set moves the read position back to the first word of the frame in progress. The next read returns that word with `rsp_sop`, and frames written behind it are kept.
- R11: `wr_full` is 1 while DEPTH words are held. Words are released only when a frame's end-of-frame word is read with no collision taken in the same cycle. Writes while full are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one word into the buffer |
| wr_data | input | DATA_W | Word to store |
| wr_sop | input | 1 | Word is the first of a frame |
| wr_eop | input | 1 | Word is the last of a frame |
| wr_err | input | 1 | Word is marked in error |
| wr_full | output | 1 | Buffer holds DEPTH words |
| rd_req | input | 1 | Single-cycle read request from the MAC |
| rsp_valid | output | 1 | Response carries a word |
| rsp_underflow | output | 1 | Response reports no word available |
| rsp_data | output | DATA_W | Word returned with rsp_valid |
| rsp_sop | output | 1 | Returned word starts a frame |
| rsp_eop | output | 1 | Returned word ends a frame |
| rsp_err | output | 1 | Returned word is marked in error |
| frame_ready | output | 1 | A complete frame is waiting |
| mac_status | input | STAT_W | Status from the MAC; bit 0 means collision |
| status_tog | output | 1 | Inverted each time status is taken |
| flushed | output | 1 | High during the flush handshake; the falling edge means done |

## Verification
Every result of this block is registered, so it appears one clock after the edge that sampled its cause. A read pulse is answered in the next cycle. Taken status shows on `status_tog` and `flushed` one cycle later. `frame_ready` follows a written or read end-of-frame word by one cycle, and `flushed` falls FLUSH_CYCLES cycles after it rose. The bench's reference model steps on the same rising edge as the design. Inputs change on the falling edge, and every comparison is made on the falling edge, half a cycle after each result became due.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

  // Kind of flush handshake currently running
  typedef enum logic {
    FK_ERR = 1'b0,
    FK_COL = 1'b1
  } flush_kind_e;

  // Status bit that requests a replay instead of a full clear
  localparam int COL_BIT = 0;

  // Marker positions above the data field of a stored word
  localparam int F_SOP = 0;
  localparam int F_EOP = 1;
  localparam int F_ERR = 2;
  localparam int N_FLAGS = 3;

endpackage

// File: rtl/tfr_store.sv
module tfr_store #(
  parameter int WORD_W = 35,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_fire,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  // Storage only; no reset on the data array
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      mem_q[wr_addr] <= wr_word;
    end
  end

  // Read is combinational so the end marker is known in the request cycle
  assign rd_word = mem_q[rd_addr];

endmodule

// File: rtl/tfr_flush_ctrl.sv
module tfr_flush_ctrl
  import tfr_pkg::*;
#(
  parameter int STAT_W       = 4,
  parameter int FLUSH_CYCLES = 2,
  localparam int CW          = $clog2(FLUSH_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] mac_status,
  output logic              status_tog,
  output logic              flushed,
  output logic              col_evt,
  output logic              err_evt,
  output logic              wr_block
);

  logic        armed_q, armed_d;
  logic        tog_q, tog_d;
  logic [CW-1:0] cnt_q, cnt_d;
  flush_kind_e kind_q, kind_d;
  logic        busy, take, any_stat;

  assign any_stat = |mac_status;
  assign busy     = (cnt_q != '0);
  assign take     = armed_q & any_stat & ~busy;
  assign col_evt  = take & mac_status[COL_BIT];
  assign err_evt  = take & ~mac_status[COL_BIT];

  always_comb begin
    armed_d = armed_q;
    tog_d   = tog_q;
    cnt_d   = cnt_q;
    kind_d  = kind_q;
    if (take) begin
      armed_d = 1'b0;
      tog_d   = ~tog_q;
      cnt_d   = CW'(FLUSH_CYCLES);
      kind_d  = mac_status[COL_BIT] ? FK_COL : FK_ERR;
    end else begin
      if (!any_stat) begin
        armed_d = 1'b1;
      end
      if (busy) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      tog_q   <= 1'b0;
      cnt_q   <= '0;
      kind_q  <= FK_ERR;
    end else begin
      armed_q <= armed_d;
      tog_q   <= tog_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
    end
  end

  assign status_tog = tog_q;
  assign flushed    = busy;
  assign wr_block   = busy & (kind_q == FK_ERR);

endmodule

// File: rtl/tfr_rd_ctrl.sv
module tfr_rd_ctrl
  import tfr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int WORD_W = DATA_W + N_FLAGS,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_is_eop,
  input  logic              wr_block,
  input  logic              err_evt,
  input  logic              col_evt,
  input  logic              rd_req,
  input  logic [WORD_W-1:0] rd_word,
  output logic              wr_fire,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     rd_addr,
  output logic              full,
  output logic              frames_nz,
  output logic              rsp_valid,
  output logic              rsp_uf,
  output logic [WORD_W-1:0] rsp_word
);

  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [PW-1:0] base_q, base_d;
  logic [PW-1:0] frames_q, frames_d;
  logic [PW-1:0] used;
  logic          avail, do_rd, rd_sop, rd_eop, inc, dec;
  logic          rsp_valid_q, rsp_uf_q;
  logic [WORD_W-1:0] rsp_word_q;

  assign used    = wr_ptr_q - base_q;
  assign full    = (used == PW'(DEPTH));
  assign avail   = (wr_ptr_q != rd_ptr_q);
  assign wr_fire = wr_en & ~full & ~wr_block & ~err_evt;
  assign do_rd   = rd_req & avail;
  assign rd_sop  = rd_word[DATA_W + F_SOP];
  assign rd_eop  = rd_word[DATA_W + F_EOP];
  assign inc     = wr_fire & wr_is_eop;
  assign dec     = do_rd & rd_eop & ~col_evt;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    base_d   = base_q;
    frames_d = frames_q + PW'(inc) - PW'(dec);
    if (err_evt) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      base_d   = '0;
      frames_d = '0;
    end else begin
      if (wr_fire) begin
        wr_ptr_d = wr_ptr_q + 1'b1;
      end
      if (col_evt) begin
        rd_ptr_d = base_q;
      end else if (do_rd) begin
        rd_ptr_d = rd_ptr_q + 1'b1;
        if (rd_eop) begin
          base_d = rd_ptr_q + 1'b1;
        end else if (rd_sop) begin
          base_d = rd_ptr_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      base_q      <= '0;
      frames_q    <= '0;
      rsp_valid_q <= 1'b0;
      rsp_uf_q    <= 1'b0;
    end else begin
      wr_ptr_q    <= wr_ptr_d;
      rd_ptr_q    <= rd_ptr_d;
      base_q      <= base_d;
      frames_q    <= frames_d;
      rsp_valid_q <= do_rd;
      rsp_uf_q    <= rd_req & ~avail;
    end
  end

  // Response word register, loaded only on a served read
  always_ff @(posedge clk) begin
    if (do_rd) begin
      rsp_word_q <= rd_word;
    end
  end

  assign wr_addr   = wr_ptr_q[AW-1:0];
  assign rd_addr   = rd_ptr_q[AW-1:0];
  assign frames_nz = (frames_q != '0);
  assign rsp_valid = rsp_valid_q;
  assign rsp_uf    = rsp_uf_q;
  assign rsp_word  = rsp_word_q;

endmodule

// File: rtl/tx_pkt_fifo_resp.sv
module tx_pkt_fifo_resp
  import tfr_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int DEPTH        = 16,
  parameter int STAT_W       = 4,
  parameter int FLUSH_CYCLES = 2,
  localparam int WORD_W      = DATA_W + N_FLAGS,
  localparam int AW          = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic              wr_err,
  output logic              wr_full,
  input  logic              rd_req,
  output logic              rsp_valid,
  output logic              rsp_underflow,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_sop,
  output logic              rsp_eop,
  output logic              rsp_err,
  output logic              frame_ready,
  input  logic [STAT_W-1:0] mac_status,
  output logic              status_tog,
  output logic              flushed
);

  logic              wr_fire, full, frames_nz;
  logic              col_evt, err_evt, wr_block;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [WORD_W-1:0] wr_word, rd_word, rsp_word;
  logic [N_FLAGS-1:0] wr_flags;

  always_comb begin
    wr_flags        = '0;
    wr_flags[F_SOP] = wr_sop;
    wr_flags[F_EOP] = wr_eop;
    wr_flags[F_ERR] = wr_err;
  end
  assign wr_word = {wr_flags, wr_data};

  tfr_store #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .clk     (clk),
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .wr_word (wr_word),
    .rd_addr (rd_addr),
    .rd_word (rd_word)
  );

  tfr_flush_ctrl #(
    .STAT_W       (STAT_W),
    .FLUSH_CYCLES (FLUSH_CYCLES)
  ) u_flush (
    .clk        (clk),
    .rst_n      (rst_n),
    .mac_status (mac_status),
    .status_tog (status_tog),
    .flushed    (flushed),
    .col_evt    (col_evt),
    .err_evt    (err_evt),
    .wr_block   (wr_block)
  );

  tfr_rd_ctrl #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_is_eop (wr_eop),
    .wr_block  (wr_block),
    .err_evt   (err_evt),
    .col_evt   (col_evt),
    .rd_req    (rd_req),
    .rd_word   (rd_word),
    .wr_fire   (wr_fire),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .full      (full),
    .frames_nz (frames_nz),
    .rsp_valid (rsp_valid),
    .rsp_uf    (rsp_underflow),
    .rsp_word  (rsp_word)
  );

  assign wr_full     = full;
  assign frame_ready = frames_nz & ~flushed;
  assign rsp_data    = rsp_word[DATA_W-1:0];
  assign rsp_sop     = rsp_valid & rsp_word[DATA_W + F_SOP];
  assign rsp_eop     = rsp_valid & rsp_word[DATA_W + F_EOP];
  assign rsp_err     = rsp_valid & rsp_word[DATA_W + F_ERR];

endmodule

// File: rtl/tx_pkt_fifo_resp_chk.sv
module tx_pkt_fifo_resp_chk #(
  parameter int STAT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              rsp_valid,
  input logic              rsp_underflow,
  input logic              frame_ready,
  input logic              flushed,
  input logic              status_tog,
  input logic              wr_full,
  input logic [STAT_W-1:0] mac_status
);

  // R3: every request gets exactly one kind of answer in the next cycle
  assert_one_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rsp_valid ^ rsp_underflow));

  // R3: no answer without a request
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!rsp_valid && !rsp_underflow));

  // R6: an underflow never follows a cycle where a frame was announced
  assert_uf_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_underflow |-> !$past(frame_ready));

  // R7: the flush handshake starts together with an acknowledge toggle
  assert_tog_on_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flushed) |-> (status_tog != $past(status_tog)));

  // R8: no frame is announced during the handshake
  assert_ready_low_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flushed |-> !frame_ready);

  // R11: a full buffer stays full without reads or status
  assert_full_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_full && !rd_req && (mac_status == '0)) |=> wr_full);

endmodule

bind tx_pkt_fifo_resp tx_pkt_fifo_resp_chk #(
  .STAT_W (STAT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_req        (rd_req),
  .rsp_valid     (rsp_valid),
  .rsp_underflow (rsp_underflow),
  .frame_ready   (frame_ready),
  .flushed       (flushed),
  .status_tog    (status_tog),
  .wr_full       (wr_full),
  .mac_status    (mac_status)
);

// File: tb/tx_pkt_fifo_resp_tb.sv
module tx_pkt_fifo_resp_tb;

  localparam int DW    = 32;
  localparam int DEPTH = 16;
  localparam int SW    = 4;
  localparam int FC    = 2;

  logic clk, rst_n;
  logic wr_en, wr_sop, wr_eop, wr_err, rd_req;
  logic [DW-1:0] wr_data;
  logic [SW-1:0] mac_status;
  logic wr_full, rsp_valid, rsp_underflow, rsp_sop, rsp_eop, rsp_err;
  logic frame_ready, status_tog, flushed;
  logic [DW-1:0] rsp_data;

  int n_checks = 0;
  int n_errors = 0;
  bit checking = 0;

  tx_pkt_fifo_resp #(
    .DATA_W (DW), .DEPTH (DEPTH), .STAT_W (SW), .FLUSH_CYCLES (FC)
  ) u_dut (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_en), .wr_data (wr_data), .wr_sop (wr_sop), .wr_eop (wr_eop),
    .wr_err (wr_err), .wr_full (wr_full),
    .rd_req (rd_req), .rsp_valid (rsp_valid), .rsp_underflow (rsp_underflow),
    .rsp_data (rsp_data), .rsp_sop (rsp_sop), .rsp_eop (rsp_eop), .rsp_err (rsp_err),
    .frame_ready (frame_ready), .mac_status (mac_status),
    .status_tog (status_tog), .flushed (flushed)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  typedef struct {
    logic [DW-1:0] d;
    bit s;
    bit e;
    bit r;
  } wd_t;

  wd_t mq[$];
  int  m_idx, m_frames, m_cnt;
  bit  m_armed, m_tog, m_kcol, m_v, m_u;
  wd_t m_w;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_idx = 0; m_frames = 0; m_cnt = 0;
      m_armed = 1; m_tog = 0; m_kcol = 0; m_v = 0; m_u = 0;
    end else begin
      bit cap, col, ferr, blk, dw, dr;
      wd_t nw;
      cap  = m_armed && (mac_status != 0) && (m_cnt == 0);
      col  = cap && mac_status[0];
      ferr = cap && !mac_status[0];
      blk  = (m_cnt > 0 && !m_kcol) || ferr;
      dw   = wr_en && (mq.size() < DEPTH) && !blk;
      dr   = rd_req && (m_idx < mq.size());
      m_v  = dr;
      m_u  = rd_req && !dr;
      if (dr) m_w = mq[m_idx];
      if (ferr) begin
        mq.delete(); m_idx = 0; m_frames = 0;
      end else begin
        if (col) m_idx = 0;
        else if (dr) begin
          if (m_w.e) begin
            m_frames--;
            repeat (m_idx + 1) void'(mq.pop_front());
            m_idx = 0;
          end else if (m_w.s) begin
            repeat (m_idx) void'(mq.pop_front());
            m_idx = 1;
          end else m_idx++;
        end
        if (dw) begin
          nw.d = wr_data; nw.s = wr_sop; nw.e = wr_eop; nw.r = wr_err;
          mq.push_back(nw);
          if (wr_eop) m_frames++;
        end
      end
      if (cap) begin
        m_armed = 0; m_tog = !m_tog; m_cnt = FC; m_kcol = mac_status[0];
      end else begin
        if (mac_status == 0) m_armed = 1;
        if (m_cnt > 0) m_cnt--;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk("R3", 64'(rsp_valid), 64'(m_v), "rsp_valid");
      chk("R6", 64'(rsp_underflow), 64'(m_u), "rsp_underflow");
      chk("R2", 64'(frame_ready), 64'((m_frames > 0) && (m_cnt == 0)), "frame_ready");
      chk("R8", 64'(flushed), 64'(m_cnt > 0), "flushed");
      chk("R7", 64'(status_tog), 64'(m_tog), "status_tog");
      chk("R11", 64'(wr_full), 64'(mq.size() == DEPTH), "wr_full");
      if (m_v) begin
        chk("R4", 64'(rsp_data), 64'(m_w.d), "rsp_data");
        chk("R4", 64'(rsp_sop), 64'(m_w.s), "rsp_sop");
        chk("R4", 64'(rsp_eop), 64'(m_w.e), "rsp_eop");
        chk("R5", 64'(rsp_err), 64'(m_w.r), "rsp_err");
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(logic [DW-1:0] d, bit s, bit e, bit r);
    wr_en = 1; wr_data = d; wr_sop = s; wr_eop = e; wr_err = r;
    @(negedge clk);
    wr_en = 0; wr_sop = 0; wr_eop = 0; wr_err = 0;
  endtask

  task automatic rd();
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_data = '0; wr_sop = 0; wr_eop = 0; wr_err = 0;
    rd_req = 0; mac_status = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", 64'(frame_ready), 64'd0, "frame_ready in reset");
    chk("R1", 64'(rsp_valid), 64'd0, "rsp_valid in reset");
    chk("R1", 64'(rsp_underflow), 64'd0, "rsp_underflow in reset");
    chk("R1", 64'(flushed), 64'd0, "flushed in reset");
    chk("R1", 64'(status_tog), 64'd0, "status_tog in reset");
    chk("R1", 64'(wr_full), 64'd0, "wr_full in reset");
    rst_n = 1;
    checking = 1;
    idle(2);

    // R6: read on empty buffer
    rd();
    chk("R6", 64'(rsp_underflow), 64'd1, "underflow on empty");

    // R2, R4: multi-word frame then a one-word frame
    wr(32'hA000_0000, 1, 0, 0);
    wr(32'hA000_0001, 0, 0, 0);
    chk("R2", 64'(frame_ready), 64'd0, "ready before eop");
    wr(32'hA000_0002, 0, 1, 0);
    chk("R2", 64'(frame_ready), 64'd1, "ready after eop");
    wr(32'hB000_0000, 1, 1, 0);
    for (int i = 0; i < 3; i++) rd();
    rd();
    chk("R4", 64'({rsp_sop, rsp_eop}), 64'd3, "one-word frame flags");
    rd();
    idle(2);

    // R5: error-marked word with no status, then a clean frame
    wr(32'hC000_0000, 1, 0, 0);
    wr(32'hC000_0001, 0, 0, 1);
    wr(32'hC000_0002, 0, 1, 0);
    wr(32'hD000_0000, 1, 1, 0);
    rd(); rd();
    chk("R5", 64'(rsp_err), 64'd1, "err on marked word");
    rd(); rd();
    chk("R5", 64'(rsp_data), 64'hD000_0000, "next frame intact");
    idle(2);

    // R10: collision replays the current frame, later frame kept
    wr(32'hE000_0000, 1, 0, 0);
    wr(32'hE000_0001, 0, 0, 0);
    wr(32'hE000_0002, 0, 0, 0);
    wr(32'hE000_0003, 0, 1, 0);
    wr(32'hF000_0000, 1, 1, 0);
    rd(); rd();
    mac_status = 4'b0001;
    @(negedge clk);
    chk("R7", 64'(status_tog), 64'd1, "toggle after collision status");
    chk("R8", 64'(flushed), 64'd1, "flushed high after status");
    mac_status = 4'b0001;   // held: must not be taken twice
    idle(FC);
    mac_status = '0;
    chk("R8", 64'(flushed), 64'd0, "flushed low after handshake");
    chk("R7", 64'(status_tog), 64'd1, "one toggle per event");
    idle(1);
    rd();
    chk("R10", 64'(rsp_data), 64'hE000_0000, "replay restarts at first word");
    chk("R10", 64'(rsp_sop), 64'd1, "replay carries sop");
    for (int i = 0; i < 4; i++) rd();
    chk("R10", 64'(rsp_data), 64'hF000_0000, "later frame kept");
    idle(2);

    // R9: error status empties the buffer, writes dropped during handshake
    wr(32'h1000_0000, 1, 0, 0);
    wr(32'h1000_0001, 0, 1, 0);
    rd();
    mac_status = 4'b0100;
    wr(32'h2000_0000, 1, 1, 0);
    mac_status = '0;
    wr(32'h3000_0000, 1, 1, 0);
    idle(FC + 1);
    chk("R9", 64'(frame_ready), 64'd0, "no frame after error flush");
    rd();
    chk("R9", 64'(rsp_underflow), 64'd1, "buffer emptied by flush");
    idle(2);

    // R11: fill to capacity, overflow write ignored
    for (int i = 0; i < DEPTH; i++) wr(32'h4000_0000 + 32'(i), i == 0, i == DEPTH - 1, 0);
    chk("R11", 64'(wr_full), 64'd1, "full at capacity");
    wr(32'h5000_0000, 1, 1, 0);
    chk("R11", 64'(wr_full), 64'd1, "still full after ignored write");
    for (int i = 0; i < DEPTH; i++) rd();
    chk("R11", 64'(rsp_data), 64'h4000_000F, "last stored word");
    chk("R11", 64'(wr_full), 64'd0, "space released after eop");
    rd();
    chk("R11", 64'(rsp_underflow), 64'd1, "overflow word was not stored");

    // R3: back-to-back reads overlapped with writes
    fork
      begin
        for (int i = 0; i < 6; i++) wr(32'h6000_0000 + 32'(i), i == 0, i == 5, 0);
      end
      begin
        idle(2);
        for (int i = 0; i < 8; i++) rd();
      end
    join
    idle(4);

    checking = 0;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule